// File: doc/BRIEF.md
# Stretchable External Data-Bus Cycle Generator

This block runs one external data-memory access on a multiplexed byte-wide bus. A requester presents a 16-bit address, a direction flag, a write byte and a 3-bit stretch code. The block then drives a latch-enable pulse while the low address byte is on the shared bus. It keeps the high address byte on its own bus and fires exactly one active-low strobe, read or write. For writes it drives the data byte onto the shared bus. For reads it releases the shared bus and captures the byte the memory returns.

The stretch code sets two things. It sets the total length of the access in machine cycles. It also places extra whole clocks at fixed points: after the latch enable falls, before the strobe falls, inside the strobe, and after the strobe rises. Codes 4 and above add a larger step of hold and width. One synchronous clock paces everything, and a parameter sets how many of its clocks make one machine cycle.

The access ends with a one-clock done pulse. A busy flag holds off new requests until the bus is idle again.

Top module: `xbus_cycle_gen`

## Requirements
- R1: After reset, busy, done, ale and ad_oe are 0, rd_n and wr_n are 1, and addr_hi is 0.
- R2: A request is taken on a clock edge where req is 1 and busy is 0. In the first clock of the access (clock t=0), ale is 1, ad_oe is 1 and ad_out carries addr[7:0].
- R3: Let k be the stretch code. ale is 0 from t=1. The low address stays on ad_out with ad_oe=1 through t=1+a, where a is 1 for k≠0 and 0 for k=0. The strobe falls at t=f, with f=3+a+p and p = 0 for k=0 and p = 4k−2 otherwise, so p runs 0,2,6,…,26.
- R4: The strobe stays low for 1+w clocks. w is 0 for k=0, 1 for k=1..3 and 5 for k=4..7.
- R5: addr_hi equals addr[15:8] from t=0 until 1+h clocks after the strobe rises, where h is 4 for k≥4 and 0 otherwise. After that, and while idle, addr_hi is 0.
- R6: On a write, ad_oe is 1 and ad_out equals wdata from t=2+a until 1+g clocks after wr_n rises, where g is 1 for k≥4 and 0 otherwise. ad_oe is 0 after that.
- R7: On a read, ad_oe is 0 from t=2+a to the end of the access. rdata takes the value on ad_in during the last clock in which rd_n is 0, and holds it until the next read.
- R8: busy is 1 for exactly (k+2)·CLKS_PER_MC clocks. done is 1 only in the last of them, and busy is 0 in the clock that follows.
- R9: While busy is 1, req, addr, we, wdata and stretch are ignored. The access in progress keeps the values taken when it was accepted.
- R10: A read drives only rd_n low and a write drives only wr_n low. The two strobes are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request, taken when busy is 0 |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 16 | Access address |
| wdata | input | 8 | Write byte |
| stretch | input | 3 | Stretch code, 0..7 |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-clock pulse in the last clock of the access |
| rdata | output | 8 | Byte captured by the last read |
| ale | output | 1 | Address latch enable, active high |
| ad_out | output | 8 | Shared bus value, driven when ad_oe is 1 |
| ad_oe | output | 1 | Shared bus output enable |
| ad_in | input | 8 | Shared bus value read back from the pads |
| addr_hi | output | 8 | High address byte bus |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
Every pin-level result is a decode of registered state, so it appears in the clock after the accepting edge and is indexed by t from that clock. The one exception is rdata, which is registered at the edge that ends the last strobe-low clock. The bench counts t from the accepting edge and samples every output on the falling edge of each clock from t=0 to t=(k+2)·CLKS_PER_MC. It compares each sample against windows computed from the stretch code. It changes ad_in so that only the final strobe-low clock carries the expected read byte, and it checks rdata once the block is idle. All sixteen combinations of code and direction are swept, with conflicting request traffic applied during each access.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    localparam int SEG_W = 6;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ALE,
        PH_ALAT,
        PH_SETUP,
        PH_STRB,
        PH_HOLD,
        PH_PAD
    } phase_e;

    // Lengths in clocks of the code-dependent segments of one access.
    typedef struct packed {
        logic [SEG_W-1:0] alat;
        logic [SEG_W-1:0] setup;
        logic [SEG_W-1:0] strb;
        logic [SEG_W-1:0] hold;
        logic [SEG_W-1:0] wdh;
    } seg_t;

    // extra clocks with low address held after the latch enable falls
    function automatic int dly_alat(input logic [2:0] k);
        return (k != 3'd0) ? 1 : 0;
    endfunction

    // extra clocks before the strobe falls
    function automatic int dly_pre(input logic [2:0] k);
        return (k == 3'd0) ? 0 : 4 * int'(k) - 2;
    endfunction

    // extra strobe width
    function automatic int dly_in(input logic [2:0] k);
        if (k == 3'd0) return 0;
        return (k < 3'd4) ? 1 : 5;
    endfunction

    // extra address hold after the strobe rises
    function automatic int dly_post(input logic [2:0] k);
        return (k >= 3'd4) ? 4 : 0;
    endfunction

    // extra write-data hold after the strobe rises
    function automatic int dly_wdata(input logic [2:0] k);
        return (k >= 3'd4) ? 1 : 0;
    endfunction

endpackage

// File: rtl/xbus_seg_calc.sv
module xbus_seg_calc
    import xbus_pkg::*;
#(
    parameter int CLKS_PER_MC = 6,
    parameter int CW          = 6
) (
    input  logic [2:0]    code,
    output seg_t          seg,
    output logic [CW-1:0] pad_len
);

    // fixed base clocks: ale 1, alat 1, setup 1, strobe 1, hold 1
    localparam int BASE_CLKS = 5;

    int total;
    int used;

    always_comb begin
        seg.alat  = SEG_W'(1 + dly_alat(code));
        seg.setup = SEG_W'(1 + dly_pre(code));
        seg.strb  = SEG_W'(1 + dly_in(code));
        seg.hold  = SEG_W'(1 + dly_post(code));
        seg.wdh   = SEG_W'(1 + dly_wdata(code));
        total     = (int'(code) + 2) * CLKS_PER_MC;
        used      = BASE_CLKS + dly_alat(code) + dly_pre(code)
                    + dly_in(code) + dly_post(code);
        pad_len   = CW'(total - used);
    end

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [2:0]    stretch_i,
    input  seg_t          seg_i,
    input  logic [CW-1:0] pad_len_i,
    input  logic [DW-1:0] ad_in,
    output phase_e        phase_o,
    output logic [CW-1:0] cnt_o,
    output logic          we_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] wdata_o,
    output logic [2:0]    code_o,
    output logic [DW-1:0] rdata_o,
    output logic          busy_o,
    output logic          done_o
);

    typedef struct packed {
        phase_e        phase;
        logic [CW-1:0] cnt;
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [2:0]    code;
        logic [DW-1:0] rdata;
    } st_t;

    st_t st_d, st_q;
    logic [CW-1:0] len_d;
    logic          last_d;

    always_comb begin
        unique case (st_q.phase)
            PH_ALE:   len_d = CW'(1);
            PH_ALAT:  len_d = CW'(seg_i.alat);
            PH_SETUP: len_d = CW'(seg_i.setup);
            PH_STRB:  len_d = CW'(seg_i.strb);
            PH_HOLD:  len_d = CW'(seg_i.hold);
            PH_PAD:   len_d = pad_len_i;
            default:  len_d = CW'(1);
        endcase
        last_d = (st_q.cnt == len_d - CW'(1));
    end

    always_comb begin
        st_d = st_q;
        if (st_q.phase == PH_IDLE) begin
            if (req) begin
                st_d.phase = PH_ALE;
                st_d.cnt   = '0;
                st_d.we    = we_i;
                st_d.addr  = addr_i;
                st_d.wdata = wdata_i;
                st_d.code  = stretch_i;
            end
        end else if (!last_d) begin
            st_d.cnt = st_q.cnt + CW'(1);
        end else begin
            st_d.cnt = '0;
            unique case (st_q.phase)
                PH_ALE:   st_d.phase = PH_ALAT;
                PH_ALAT:  st_d.phase = PH_SETUP;
                PH_SETUP: st_d.phase = PH_STRB;
                PH_STRB: begin
                    st_d.phase = PH_HOLD;
                    if (!st_q.we) st_d.rdata = ad_in;
                end
                PH_HOLD:  st_d.phase = PH_PAD;
                default:  st_d.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.phase;
    assign cnt_o   = st_q.cnt;
    assign we_o    = st_q.we;
    assign addr_o  = st_q.addr;
    assign wdata_o = st_q.wdata;
    assign code_o  = st_q.code;
    assign rdata_o = st_q.rdata;
    assign busy_o  = (st_q.phase != PH_IDLE);
    assign done_o  = (st_q.phase == PH_PAD) && last_d;

endmodule

// File: rtl/xbus_drive.sv
module xbus_drive
    import xbus_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int CW = 6
) (
    input  phase_e        phase,
    input  logic [CW-1:0] cnt,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  seg_t          seg,
    output logic          ale,
    output logic [DW-1:0] ad_out,
    output logic          ad_oe,
    output logic [AW-DW-1:0] addr_hi,
    output logic          rd_n,
    output logic          wr_n
);

    logic addr_phase;
    logic wdata_hold;

    always_comb begin
        addr_phase = (phase == PH_ALE) || (phase == PH_ALAT);
        wdata_hold = (phase == PH_HOLD) && (cnt < CW'(seg.wdh));
        ale        = (phase == PH_ALE);
        rd_n       = !((phase == PH_STRB) && !we);
        wr_n       = !((phase == PH_STRB) && we);
        ad_oe      = 1'b0;
        ad_out     = '0;
        if (addr_phase) begin
            ad_oe  = 1'b1;
            ad_out = addr[DW-1:0];
        end else if (we && ((phase == PH_SETUP) || (phase == PH_STRB) || wdata_hold)) begin
            ad_oe  = 1'b1;
            ad_out = wdata;
        end
        if ((phase != PH_IDLE) && (phase != PH_PAD)) begin
            addr_hi = addr[AW-1:DW];
        end else begin
            addr_hi = '0;
        end
    end

endmodule

// File: rtl/xbus_cycle_gen.sv
module xbus_cycle_gen
    import xbus_pkg::*;
#(
    parameter int CLKS_PER_MC = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic       we,
    input  logic [15:0] addr,
    input  logic [7:0] wdata,
    input  logic [2:0] stretch,
    output logic       busy,
    output logic       done,
    output logic [7:0] rdata,
    output logic       ale,
    output logic [7:0] ad_out,
    output logic       ad_oe,
    input  logic [7:0] ad_in,
    output logic [7:0] addr_hi,
    output logic       rd_n,
    output logic       wr_n
);

    // CLKS_PER_MC must be 5 or more so that code 7 fits its segments.
    localparam int AW     = 16;
    localparam int DW     = 8;
    localparam int CW_RAW = $clog2(9 * CLKS_PER_MC + 1);
    localparam int CW     = (CW_RAW < SEG_W) ? SEG_W : CW_RAW;

    phase_e        phase;
    logic [CW-1:0] cnt;
    logic          we_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [2:0]    code_q;
    seg_t          seg;
    logic [CW-1:0] pad_len;

    xbus_seg_calc #(
        .CLKS_PER_MC(CLKS_PER_MC),
        .CW         (CW)
    ) u_seg (
        .code   (code_q),
        .seg    (seg),
        .pad_len(pad_len)
    );

    xbus_seq #(
        .AW(AW),
        .DW(DW),
        .CW(CW)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .we_i     (we),
        .addr_i   (addr),
        .wdata_i  (wdata),
        .stretch_i(stretch),
        .seg_i    (seg),
        .pad_len_i(pad_len),
        .ad_in    (ad_in),
        .phase_o  (phase),
        .cnt_o    (cnt),
        .we_o     (we_q),
        .addr_o   (addr_q),
        .wdata_o  (wdata_q),
        .code_o   (code_q),
        .rdata_o  (rdata),
        .busy_o   (busy),
        .done_o   (done)
    );

    xbus_drive #(
        .AW(AW),
        .DW(DW),
        .CW(CW)
    ) u_drv (
        .phase  (phase),
        .cnt    (cnt),
        .we     (we_q),
        .addr   (addr_q),
        .wdata  (wdata_q),
        .seg    (seg),
        .ale    (ale),
        .ad_out (ad_out),
        .ad_oe  (ad_oe),
        .addr_hi(addr_hi),
        .rd_n   (rd_n),
        .wr_n   (wr_n)
    );

endmodule

// File: rtl/xbus_cycle_chk.sv
module xbus_cycle_chk #(
    parameter int CLKS_PER_MC = 6
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req,
    input logic [2:0] stretch,
    input logic       busy,
    input logic       done,
    input logic       ale,
    input logic       ad_oe,
    input logic [7:0] addr_hi,
    input logic       rd_n,
    input logic       wr_n
);

    logic [15:0] len_c;
    logic [2:0]  code_c;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_c  <= '0;
            code_c <= '0;
        end else if (req && !busy) begin
            len_c  <= '0;
            code_c <= stretch;
        end else if (busy) begin
            len_c  <= len_c + 16'd1;
        end
    end

    // R10
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // R7
    rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);

    // R2
    ale_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (ad_oe && busy));

    // R5
    strobe_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> (busy && $stable(addr_hi)));

    // R8
    done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R8
    length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (32'(len_c) + 1 == (32'(code_c) + 2) * CLKS_PER_MC));

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

endmodule

bind xbus_cycle_gen xbus_cycle_chk #(.CLKS_PER_MC(CLKS_PER_MC)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (req),
    .stretch(stretch),
    .busy   (busy),
    .done   (done),
    .ale    (ale),
    .ad_oe  (ad_oe),
    .addr_hi(addr_hi),
    .rd_n   (rd_n),
    .wr_n   (wr_n)
);

// File: tb/sim_xbus_cycle_gen.sv
`timescale 1ns/1ps
module sim_xbus_cycle_gen;

    localparam int M = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0;
    logic       we = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [2:0] stretch = '0;
    logic [7:0] ad_in = '0;
    logic       busy, done, ale, ad_oe, rd_n, wr_n;
    logic [7:0] rdata, ad_out, addr_hi;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    xbus_cycle_gen #(.CLKS_PER_MC(M)) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .stretch(stretch), .busy(busy), .done(done),
        .rdata(rdata), .ale(ale), .ad_out(ad_out), .ad_oe(ad_oe),
        .ad_in(ad_in), .addr_hi(addr_hi), .rd_n(rd_n), .wr_n(wr_n)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic access(input int c, input bit w, input logic [15:0] a,
                          input logic [7:0] d, input logic [7:0] rv);
        int s1, s2, s3, s4, s5, len, fs, se, hold_end;
        bit ex_ale, ex_rd, ex_wr, ex_oe;
        logic [7:0] ex_hi, ex_ad;
        string st;
        s5 = (c != 0) ? 1 : 0;
        s1 = (c == 0) ? 0 : 4 * c - 2;
        s2 = (c == 0) ? 0 : ((c < 4) ? 1 : 5);
        s3 = (c >= 4) ? 4 : 0;
        s4 = (c >= 4) ? 1 : 0;
        len = (c + 2) * M;
        fs = 3 + s5 + s1;
        se = fs + s2;
        hold_end = se + 1 + s3;
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d; stretch = 3'(c); ad_in = ~rv;
        @(posedge clk);
        for (int t = 0; t <= len; t++) begin
            @(negedge clk);
            if (t == len) begin
                check(busy == 1'b0, "R8", "busy after end", busy, 0);
                check(done == 1'b0, "R8", "done after end", done, 0);
                check(addr_hi == 8'h00, "R5", "addr_hi idle", addr_hi, 0);
                if (!w) check(rdata == rv, "R7", "rdata", rdata, rv);
            end else begin
                ex_ale = (t == 0);
                ex_hi  = (t <= hold_end) ? a[15:8] : 8'h00;
                ex_rd  = !((t >= fs) && (t <= se) && !w);
                ex_wr  = !((t >= fs) && (t <= se) && w);
                ex_oe  = (t <= 1 + s5) || (w && (t >= 2 + s5) && (t <= se + 1 + s4));
                ex_ad  = (t <= 1 + s5) ? a[7:0] : d;
                check(ale == ex_ale, "R2", $sformatf("ale t=%0d k=%0d", t, c), ale, ex_ale);
                check(addr_hi == ex_hi, "R5", $sformatf("addr_hi t=%0d k=%0d", t, c), addr_hi, ex_hi);
                st = (t < fs) ? "R3" : ((t <= se) ? "R4" : "R10");
                check(rd_n == ex_rd, st, $sformatf("rd_n t=%0d k=%0d", t, c), rd_n, ex_rd);
                check(wr_n == ex_wr, st, $sformatf("wr_n t=%0d k=%0d", t, c), wr_n, ex_wr);
                st = (t <= 1 + s5) ? "R3" : (w ? "R6" : "R7");
                check(ad_oe == ex_oe, st, $sformatf("ad_oe t=%0d k=%0d", t, c), ad_oe, ex_oe);
                if (ex_oe)
                    check(ad_out == ex_ad, st, $sformatf("ad_out t=%0d k=%0d", t, c), ad_out, ex_ad);
                check(busy == 1'b1, "R8", $sformatf("busy t=%0d k=%0d", t, c), busy, 1);
                check(done == (t == len - 1), "R8", $sformatf("done t=%0d k=%0d", t, c), done, t == len - 1);
            end
            // R9: conflicting request traffic during the first clocks of the access
            if (t < 3) begin
                req = 1'b1; we = ~w; addr = ~a; wdata = ~d; stretch = ~3'(c);
            end else begin
                req = 1'b0;
            end
            ad_in = (t == se) ? rv : ~rv;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(busy == 1'b0, "R1", "busy", busy, 0);
        check(done == 1'b0, "R1", "done", done, 0);
        check(ale == 1'b0, "R1", "ale", ale, 0);
        check(ad_oe == 1'b0, "R1", "ad_oe", ad_oe, 0);
        check(rd_n == 1'b1, "R1", "rd_n", rd_n, 1);
        check(wr_n == 1'b1, "R1", "wr_n", wr_n, 1);
        check(addr_hi == 8'h00, "R1", "addr_hi", addr_hi, 0);
        for (int c = 0; c < 8; c++) begin
            for (int w = 0; w < 2; w++) begin
                access(c, w[0], 16'hA5C3 ^ 16'(c * 16'h1357) ^ 16'(w * 16'h0F0F),
                       8'h5A ^ 8'(c * 8'h11), 8'h3C ^ 8'(c * 8'h23));
            end
        end
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule